// File: doc/BRIEF.md
# Real-Time Clock Time Read/Set Sequencer

This block runs one complete time transfer with a nibble-wide real-time clock device. It sits above a serial register master, which moves one 4-bit register per request. A start strobe begins either a read session or a set session. The sequencer raises the device chip enable and selects 24-hour mode. It then polls the busy flag, retrying within a bounded number of attempts. When the device is free it walks through the seven time fields.

On a read, the units and tens nibbles of each field are packed into one BCD byte. All seven results appear together when the session ends. On a set, the BCD bytes are captured at the start strobe and then sent out as separate nibble writes. Every session ends with chip enable held low for a programmable number of cycles. After that the block gives either a one-cycle done pulse or a one-cycle timeout pulse. Conversion to binary and any year windowing are left to the consumer.

Top module: `rtc_time_seq`

## Requirements
- R1: After reset, ce, reg_req, done and timeout_err are low and every read-back output is zero.
- R2: Each attempt raises ce. Its first access writes 0x4 to address 14, and its second access reads address 14. Every access happens while ce is high.
- R3: If bit 0 of the address-14 read is 1, ce drops for at least CE_LOW_CYCLES cycles before the next attempt, which starts again with the 0x4 write.
- R4: If MAX_TRIES attempts in a row all read busy, the session performs no data accesses and ends with timeout_err instead of done.
- R5: Data accesses use this address order: 0,1, 2,3, 4,5, 8,9, 10,11, 12,13, 6. These cover seconds, minutes, hours, day, month, year and weekday, with the units address before the tens address.
- R6: On a read, the tens nibble of each field becomes bits 7:4 of its output byte and the units nibble becomes bits 3:0. The weekday output is the nibble read from address 6.
- R7: On a set, the access to each units address writes bits 3:0 of the field byte and the access to each tens address writes bits 7:4. Address 6 receives set_wday. The values used are the ones present at the start strobe.
- R8: At the end of a session, ce stays low for at least CE_LOW_CYCLES cycles before done or timeout_err is raised.
- R9: Start strobes have no effect while a session is in progress. If start_rd and start_set arrive in the same cycle, a read session runs.
- R10: The read-back outputs change only in the done cycle of a successful read session. Set sessions and timeouts leave them unchanged.
- R11: done and timeout_err are single-cycle pulses and are never high together.
- R12: While reg_req is high and reg_ack is low, reg_addr, reg_we and reg_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_rd | input | 1 | Start a read session (strobe) |
| start_set | input | 1 | Start a set session (strobe) |
| set_sec | input | 8 | BCD seconds to set |
| set_min | input | 8 | BCD minutes to set |
| set_hour | input | 8 | BCD hours to set |
| set_day | input | 8 | BCD day of month to set |
| set_mon | input | 8 | BCD month to set |
| set_year | input | 8 | BCD year to set |
| set_wday | input | 4 | Weekday to set |
| rd_sec | output | 8 | BCD seconds read back |
| rd_min | output | 8 | BCD minutes read back |
| rd_hour | output | 8 | BCD hours read back |
| rd_day | output | 8 | BCD day read back |
| rd_mon | output | 8 | BCD month read back |
| rd_year | output | 8 | BCD year read back |
| rd_wday | output | 4 | Weekday read back |
| done | output | 1 | Session completed (pulse) |
| timeout_err | output | 1 | Busy retry limit reached (pulse) |
| ce | output | 1 | Device chip enable |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 4 | Write nibble |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 4 | Read nibble, valid with reg_ack |

## Verification
The bench builds the sequencer with MAX_TRIES=3 and CE_LOW_CYCLES=2. With these values every busy count from zero up to one past the limit can be swept for both session kinds. The sweep therefore reaches the last successful retry and the first timeout in every combination. The short low-time lets the bench measure each chip-enable gap exactly. A behavioural device model records every access and returns arithmetically generated nibble patterns. Each set session is followed by a read, so the nibble split and the nibble packing are checked against each other.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    localparam int FIELDS     = 7;
    localparam int NSTEPS     = 13;
    localparam logic [3:0] CTRL_ADDR = 4'd14;
    localparam logic [3:0] MODE_24H  = 4'h4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MODE,
        S_POLL,
        S_XFER,
        S_GAP,
        S_END
    } seq_state_e;

    // field order: sec, min, hour, day, month, year, weekday
    typedef logic [FIELDS-1:0][7:0] bcd_bank_t;

endpackage

// File: rtl/rtc_seq_hold.sv
module rtc_seq_hold #(
    parameter int CYCLES = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(1));

    p_hold_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES));

    p_hold_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rtc_seq_steps.sv
module rtc_seq_steps
    import rtc_seq_pkg::*;
(
    input  logic [3:0] idx,
    output logic [3:0] addr,
    output logic [2:0] field,
    output logic       tens,
    output logic       last
);
    logic [3:0] base;

    always_comb begin
        if (idx >= 4'(NSTEPS - 1)) begin
            field = 3'd6;
            tens  = 1'b0;
            base  = 4'd6;
        end else begin
            field = idx[3:1];
            tens  = idx[0];
            // day and later skip the weekday/interval pair
            base  = (field < 3'd3) ? {field, 1'b0} : {field, 1'b0} + 4'd2;
        end
        addr = base + {3'b000, tens};
        last = (idx == 4'(NSTEPS - 1));
    end
endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq
    import rtc_seq_pkg::*;
#(
    parameter int MAX_TRIES     = 102,
    parameter int CE_LOW_CYCLES = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_rd,
    input  logic       start_set,
    input  logic [7:0] set_sec,
    input  logic [7:0] set_min,
    input  logic [7:0] set_hour,
    input  logic [7:0] set_day,
    input  logic [7:0] set_mon,
    input  logic [7:0] set_year,
    input  logic [3:0] set_wday,
    output logic [7:0] rd_sec,
    output logic [7:0] rd_min,
    output logic [7:0] rd_hour,
    output logic [7:0] rd_day,
    output logic [7:0] rd_mon,
    output logic [7:0] rd_year,
    output logic [3:0] rd_wday,
    output logic       done,
    output logic       timeout_err,
    output logic       ce,
    output logic       reg_req,
    output logic       reg_we,
    output logic [3:0] reg_addr,
    output logic [3:0] reg_wdata,
    input  logic       reg_ack,
    input  logic [3:0] reg_rdata
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        seq_state_e  state;
        logic        is_set;
        logic        err;
        logic [TW-1:0] tries;
        logic [3:0]  step;
        bcd_bank_t   shadow;
        bcd_bank_t   out;
        logic        done;
        logic        tmo;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [3:0] st_addr;
    logic [2:0] st_field;
    logic       st_tens, st_last;
    logic       hold_start, hold_expired;
    logic       in_hold_d, in_hold_q;

    rtc_seq_steps u_steps (
        .idx   (r_q.step),
        .addr  (st_addr),
        .field (st_field),
        .tens  (st_tens),
        .last  (st_last)
    );

    assign in_hold_d  = (r_d.state == S_GAP) || (r_d.state == S_END);
    assign in_hold_q  = (r_q.state == S_GAP) || (r_q.state == S_END);
    assign hold_start = in_hold_d && !in_hold_q;

    rtc_seq_hold #(.CYCLES(CE_LOW_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (hold_start),
        .expired (hold_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.tmo  = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start_rd || start_set) begin
                    r_d.is_set = !start_rd;
                    r_d.err    = 1'b0;
                    r_d.tries  = '0;
                    r_d.step   = '0;
                    r_d.state  = S_MODE;
                    if (start_rd)
                        r_d.shadow = '0;
                    else
                        r_d.shadow = {{4'h0, set_wday}, set_year, set_mon,
                                      set_day, set_hour, set_min, set_sec};
                end
            end
            S_MODE: if (reg_ack) r_d.state = S_POLL;
            S_POLL: begin
                if (reg_ack) begin
                    if (!reg_rdata[0]) begin
                        r_d.state = S_XFER;
                        r_d.step  = '0;
                    end else if (r_q.tries == TW'(MAX_TRIES - 1)) begin
                        r_d.err   = 1'b1;
                        r_d.state = S_END;
                    end else begin
                        r_d.tries = r_q.tries + 1'b1;
                        r_d.state = S_GAP;
                    end
                end
            end
            S_GAP: if (hold_expired) r_d.state = S_MODE;
            S_XFER: begin
                if (reg_ack) begin
                    if (!r_q.is_set) begin
                        if (st_tens) r_d.shadow[st_field][7:4] = reg_rdata;
                        else         r_d.shadow[st_field][3:0] = reg_rdata;
                    end
                    if (st_last) r_d.state = S_END;
                    else         r_d.step  = r_q.step + 1'b1;
                end
            end
            S_END: begin
                if (hold_expired) begin
                    r_d.state = S_IDLE;
                    if (r_q.err) begin
                        r_d.tmo = 1'b1;
                    end else begin
                        r_d.done = 1'b1;
                        if (!r_q.is_set) r_d.out = r_q.shadow;
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ce        = (r_q.state == S_MODE) || (r_q.state == S_POLL) ||
                       (r_q.state == S_XFER);
    assign reg_req   = ce;
    assign reg_we    = (r_q.state == S_MODE) ||
                       ((r_q.state == S_XFER) && r_q.is_set);
    assign reg_addr  = (r_q.state == S_XFER) ? st_addr : CTRL_ADDR;
    assign reg_wdata = (r_q.state == S_MODE) ? MODE_24H :
                       (st_tens ? r_q.shadow[st_field][7:4]
                                : r_q.shadow[st_field][3:0]);

    assign rd_sec      = r_q.out[0];
    assign rd_min      = r_q.out[1];
    assign rd_hour     = r_q.out[2];
    assign rd_day      = r_q.out[3];
    assign rd_mon      = r_q.out[4];
    assign rd_year     = r_q.out[5];
    assign rd_wday     = r_q.out[6][3:0];
    assign done        = r_q.done;
    assign timeout_err = r_q.tmo;

    p_req_under_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |-> ce);

    p_busy_drops_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_POLL && reg_ack && reg_rdata[0]) |=> !ce);

    p_xfer_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_XFER) |-> (reg_addr != 4'd7 && reg_addr < CTRL_ADDR));

    p_ce_low_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |-> (!ce && !$past(ce)));

    p_out_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ({rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, rd_wday} !=
         $past({rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, rd_wday}))
        |-> done);

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err));

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |=> !(done || timeout_err));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=>
        (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));
endmodule

// File: tb/rtc_time_seq_bench.sv
module rtc_time_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MT = 3;
    localparam int CL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_rd = 1'b0, start_set = 1'b0;
    logic [7:0] set_sec = '0, set_min = '0, set_hour = '0, set_day = '0,
                set_mon = '0, set_year = '0;
    logic [3:0] set_wday = '0;
    logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
    logic [3:0] rd_wday;
    logic done, timeout_err, ce, reg_req, reg_we;
    logic [3:0] reg_addr, reg_wdata;
    logic reg_ack = 1'b0;
    logic [3:0] reg_rdata = '0;

    int errors = 0, checks = 0, cyc = 0;

    rtc_time_seq #(.MAX_TRIES(MT), .CE_LOW_CYCLES(CL)) u_rtc_time_seq (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_set(start_set),
        .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour),
        .set_day(set_day), .set_mon(set_mon), .set_year(set_year),
        .set_wday(set_wday), .rd_sec(rd_sec), .rd_min(rd_min),
        .rd_hour(rd_hour), .rd_day(rd_day), .rd_mon(rd_mon),
        .rd_year(rd_year), .rd_wday(rd_wday), .done(done),
        .timeout_err(timeout_err), .ce(ce), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // device model
    logic [3:0] dev [16];
    int busy_left = 0;
    int n_log = 0;
    logic [3:0] log_addr [64];
    logic       log_we   [64];
    logic [3:0] log_data [64];
    logic       log_ce   [64];
    int wcnt = 0, hold_viol = 0;
    logic [3:0] held_addr, held_wdata;
    logic held_we;

    always @(negedge clk) begin
        if (reg_ack) begin
            reg_ack <= 1'b0;
            wcnt    <= 0;
        end else if (reg_req) begin
            if (wcnt == 0) begin
                held_addr <= reg_addr; held_we <= reg_we; held_wdata <= reg_wdata;
            end else if (reg_addr != held_addr || reg_we != held_we ||
                         (reg_we && reg_wdata != held_wdata)) begin
                hold_viol <= hold_viol + 1;
            end
            if (wcnt == 2) begin
                reg_ack <= 1'b1;
                if (n_log < 64) begin
                    log_addr[n_log] <= reg_addr; log_we[n_log] <= reg_we;
                    log_data[n_log] <= reg_wdata; log_ce[n_log] <= ce;
                end
                n_log <= n_log + 1;
                if (reg_we) begin
                    if (reg_addr != 4'd14) dev[reg_addr] <= reg_wdata;
                end else if (reg_addr == 4'd14) begin
                    reg_rdata <= {3'b010, busy_left > 0};
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end else begin
                    reg_rdata <= dev[reg_addr];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] step_addr(input int k);
        case (k)
            0: return 4'd0;  1: return 4'd1;  2: return 4'd2;  3: return 4'd3;
            4: return 4'd4;  5: return 4'd5;  6: return 4'd8;  7: return 4'd9;
            8: return 4'd10; 9: return 4'd11; 10: return 4'd12; 11: return 4'd13;
            default: return 4'd6;
        endcase
    endfunction

    function automatic logic [55:0] outs();
        return {rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year, 4'h0, rd_wday};
    endfunction

    task automatic run_session(input bit is_set, input int busy,
                               input bit poke, input bit both, input int pat);
        logic [7:0] sv [7];
        logic [55:0] prev;
        int att, lowrun, min_gap, guard, bad;
        bit seen_high, got_done, got_err, tmo, rd;
        rd  = !is_set || both;
        tmo = (busy >= MT);
        att = tmo ? MT : busy + 1;
        for (int f = 0; f < 6; f++)
            sv[f] = {4'((pat + f + busy) % 6), 4'((pat * 3 + f * 7 + busy) % 10)};
        sv[6] = {4'h0, 4'((pat + busy) % 7)};
        set_sec = sv[0]; set_min = sv[1]; set_hour = sv[2];
        set_day = sv[3]; set_mon = sv[4]; set_year = sv[5]; set_wday = sv[6][3:0];
        prev = outs();
        @(negedge clk);
        n_log = 0; busy_left = busy;
        start_rd = rd; start_set = is_set;
        @(negedge clk);
        start_rd = 0; start_set = 0;
        // later changes to the set inputs must not reach the device (R7)
        set_sec = ~sv[0]; set_min = ~sv[1]; set_hour = ~sv[2];
        set_day = ~sv[3]; set_mon = ~sv[4]; set_year = ~sv[5];
        set_wday = ~sv[6][3:0];
        lowrun = 0; min_gap = 1000; seen_high = 0; guard = 0;
        got_done = 0; got_err = 0;
        while (guard < 2000) begin
            @(negedge clk);
            guard++;
            if (poke && guard == 6) begin start_rd = 1; start_set = 1; end
            if (poke && guard == 7) begin start_rd = 0; start_set = 0; end
            if (done || timeout_err) begin
                got_done = done; got_err = timeout_err;
                break;
            end
            if (ce) begin
                if (seen_high && lowrun > 0 && lowrun < min_gap) min_gap = lowrun;
                seen_high = 1; lowrun = 0;
            end else begin
                lowrun++;
            end
        end
        chk(got_err == tmo && got_done == !tmo, "R4",
            "ending pulse (done,err)", {got_done, got_err}, {!tmo, tmo});
        chk(!(got_done && got_err), "R11", "done and timeout together",
            got_done && got_err, 0);
        chk(lowrun >= CL, "R8", "ce low cycles before end pulse", lowrun, CL);
        if (att > 1)
            chk(min_gap >= CL, "R3", "ce low gap between attempts", min_gap, CL);
        chk(n_log == 2 * att + (tmo ? 0 : 13), "R5", "access count",
            n_log, 2 * att + (tmo ? 0 : 13));
        bad = 0;
        for (int i = 0; i < att; i++) begin
            if (!(log_we[2*i] && log_addr[2*i] == 4'd14 && log_data[2*i] == 4'h4)) bad++;
            if (!(!log_we[2*i+1] && log_addr[2*i+1] == 4'd14)) bad++;
        end
        for (int i = 0; i < n_log && i < 64; i++) if (!log_ce[i]) bad++;
        chk(bad == 0, "R2", "mode write / busy poll accesses", bad, 0);
        if (!tmo && n_log == 2 * att + 13) begin
            bad = 0;
            for (int k = 0; k < 13; k++)
                if (log_addr[2*att+k] != step_addr(k) || log_we[2*att+k] != !rd) bad++;
            chk(bad == 0, "R5", "data address order", bad, 0);
            if (!rd) begin
                bad = 0;
                for (int k = 0; k < 13; k++) begin
                    logic [3:0] e;
                    if (k == 12)     e = sv[6][3:0];
                    else if (k % 2)  e = sv[k/2][7:4];
                    else             e = sv[k/2][3:0];
                    if (log_data[2*att+k] != e) bad++;
                end
                chk(bad == 0, "R7", "set nibble values", bad, 0);
            end
        end
        if (rd && !tmo) begin
            logic [55:0] e;
            e = {dev[1], dev[0], dev[3], dev[2], dev[5], dev[4], dev[9], dev[8],
                 dev[11], dev[10], dev[13], dev[12], 4'h0, dev[6]};
            chk(outs() == e, "R6", "packed read-back", int'(outs() ^ e), 0);
        end else begin
            chk(outs() == prev, "R10", "outputs unchanged", int'(outs() ^ prev), 0);
        end
        @(negedge clk);
        chk(!done && !timeout_err, "R11", "pulse lasts one cycle",
            {done, timeout_err}, 0);
        if (poke || both) begin
            repeat (10) @(negedge clk);
            chk(!reg_req && !ce, "R9", "no session after ignored strobe",
                {reg_req, ce}, 0);
        end
    endtask

    initial begin
        for (int a = 0; a < 16; a++) dev[a] = '0;
        repeat (3) @(negedge clk);
        chk(!ce && !reg_req && !done && !timeout_err, "R1", "control outputs in reset",
            {ce, reg_req, done, timeout_err}, 0);
        chk(outs() == '0, "R1", "read-back in reset", int'(outs()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ce && !reg_req, "R1", "idle after reset", {ce, reg_req}, 0);
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b <= MT + 1; b++) begin
                for (int a = 0; a < 16; a++) dev[a] = 4'((a * 7 + p * 3 + b) % 10);
                run_session(1'b0, b, 1'b0, 1'b0, p);
                run_session(1'b1, b, 1'b0, 1'b0, p);
                run_session(1'b0, 0, 1'b0, 1'b0, p);
            end
        end
        run_session(1'b0, 1, 1'b1, 1'b0, 5);
        run_session(1'b1, 0, 1'b1, 1'b0, 6);
        run_session(1'b1, 0, 1'b0, 1'b1, 7);
        chk(hold_viol == 0, "R12", "request fields stable until ack", hold_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule